// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block is the controller-side register window that a host uses to exchange work with a storage controller core. Over a 32-bit memory-mapped slave port the host takes free request slots, posts requests, collects completions and hands finished slots back. All four operations go through two queue-port addresses, and the direction of the access selects the operation. Beside the queues the block holds two inbound and two outbound message registers for non-queued commands, an inbound doorbell, and a status and mask register pair for each direction.

On the local side the controller core sees posted requests as a valid/ready stream with a decode of the host-memory form. It pushes completions into a second valid/ready stream, reads the inbound messages and the doorbell, and writes the outbound messages. The free pool starts full, holding `DEPTH` slot offsets spaced `SLOT_STEP` apart from `SLOT_BASE`. The host interrupt is raised whenever an outbound status bit is set and not masked. The local interrupt follows the same rule on the inbound side.

Back-pressure: `lreq_data` is held stable while `lreq_valid` is high and `lreq_ready` is low, and an entry leaves only when both are high. `lcpl_ready` is low while the completion queue is full. A completion moves only when `lcpl_valid` and `lcpl_ready` are both high. The host bus has no back-pressure. `host_rd` and `host_wr` must not be high in the same cycle.

Top module: `qpmu_top`

## Requirements
- R1: After reset, the completion queue and the request queue are empty, both status registers and both mask registers read 0, `host_irq` and `local_irq` are low, and the free pool is full with slots `SLOT_BASE + i*SLOT_STEP`.
- R2: A read of offset 0x40 returns the oldest free slot and removes it from the pool. `host_rvalid` is high with the data in the cycle after `host_rd`. With the pool empty the read returns 0xFFFFFFFF and changes nothing.
- R3: A write to offset 0x40 appends the value to the request queue. If that queue is full the value is dropped and inbound status bit 3 (post overflow) is set.
- R4: `lreq_host` equals bit 31 of the head request. `lreq_addr` is the low 27 bits shifted left by 5 when bit 31 is set, and the request value itself otherwise.
- R5: Completions accepted on the local stream are read from offset 0x44 in arrival order. `lcpl_ready` is low when `DEPTH` completions are waiting. A read with no completion returns 0xFFFFFFFF and changes nothing.
- R6: A write to offset 0x44 returns the value to the tail of the free pool. If the pool is full the value is dropped and outbound status bit 3 (return overflow) is set.
- R7: Host writes to 0x10 and 0x14 store inbound messages 0 and 1. The host can read them back, they drive `loc_imsg0` and `loc_imsg1`, and they set inbound status bits 0 and 1. Local writes of the outbound messages (`loc_omsg_sel` 0 or 1) are read at 0x18 and 0x1C and set outbound status bits 1 and 2. Host writes to 0x18 and 0x1C are ignored.
- R8: A host write to 0x20 ORs its data into the doorbell and, if the data is non-zero, sets inbound status bit 2. `loc_db_clr` clears doorbell bits, and a clear wins over a set of the same bit in the same cycle.
- R9: Writing 1 to a sticky status bit at 0x24 or 0x30 clears it. Outbound status bit 0 reads 1 exactly while a completion is waiting, and writing to it has no effect.
- R10: The masks at 0x28 and 0x34 are 4 bits wide and a 1 masks. `host_irq` is the OR of outbound status AND NOT the outbound mask. `local_irq` is the same for the inbound pair.
- R11: While `lreq_valid` is high and `lreq_ready` is low, `lreq_valid` stays high and `lreq_data` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, one cycle after host_rd |
| host_rvalid | output | 1 | host_rdata is valid |
| host_irq | output | 1 | Host interrupt |
| lreq_valid | output | 1 | A posted request is available |
| lreq_ready | input | 1 | Core accepts the request |
| lreq_data | output | 32 | Raw posted value |
| lreq_host | output | 1 | Request lives in host memory |
| lreq_addr | output | 32 | Decoded packet address or offset |
| lcpl_valid | input | 1 | Core offers a completion |
| lcpl_ready | output | 1 | Completion queue has room |
| lcpl_data | input | 32 | Completion value |
| loc_imsg0 | output | 32 | Inbound message 0 |
| loc_imsg1 | output | 32 | Inbound message 1 |
| loc_omsg_wr | input | 1 | Core writes an outbound message |
| loc_omsg_sel | input | 1 | Outbound message index |
| loc_omsg_data | input | 32 | Outbound message value |
| loc_doorbell | output | 32 | Doorbell bits |
| loc_db_clr | input | 32 | Doorbell bits to clear |
| local_irq | output | 1 | Core interrupt from inbound status |

## Verification
A wrong queue pointer or count shows at the host port on the very next queue-port read: a slot comes out of order, 0xFFFFFFFF appears where a value was due, or a value appears where 0xFFFFFFFF was due. The one-cycle read latency means the error is visible one cycle after the access. A sticky bit that is set or cleared wrongly shows as a status readback mismatch and as a wrong `host_irq` or `local_irq` level in the same cycle the status settles. A bad decode or an unstable stream head shows on `lreq_*` while the core holds `lreq_ready` low.

// File: rtl/qpmu_pkg.sv
package qpmu_pkg;
  localparam int DATA_W = 32;
  localparam int STS_W  = 4;

  localparam logic [7:0] OFF_IMSG0 = 8'h10;
  localparam logic [7:0] OFF_IMSG1 = 8'h14;
  localparam logic [7:0] OFF_OMSG0 = 8'h18;
  localparam logic [7:0] OFF_OMSG1 = 8'h1C;
  localparam logic [7:0] OFF_DBELL = 8'h20;
  localparam logic [7:0] OFF_ISTS  = 8'h24;
  localparam logic [7:0] OFF_IMASK = 8'h28;
  localparam logic [7:0] OFF_OSTS  = 8'h30;
  localparam logic [7:0] OFF_OMASK = 8'h34;
  localparam logic [7:0] OFF_IQP   = 8'h40;
  localparam logic [7:0] OFF_OQP   = 8'h44;

  localparam logic [DATA_W-1:0] EMPTY_WORD = '1;

  // inbound status bits
  localparam int IB_MSG0 = 0;
  localparam int IB_MSG1 = 1;
  localparam int IB_DB   = 2;
  localparam int IB_OVF  = 3;
  // outbound status bits
  localparam int OB_PEND = 0;
  localparam int OB_MSG0 = 1;
  localparam int OB_MSG1 = 2;
  localparam int OB_OVF  = 3;
endpackage

// File: rtl/qpmu_fifo.sv
module qpmu_fifo #(
  parameter int W         = 32,
  parameter int DEPTH     = 16,
  parameter bit INIT_FULL = 1'b0,
  parameter int INIT_BASE = 0,
  parameter int INIT_STEP = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full_o  = (count == FULL_CNT);
  assign empty_o = (count == '0);
  assign dout_o  = mem[rptr];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= INIT_FULL ? FULL_CNT : '0;
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= W'(INIT_BASE) + W'(i) * W'(INIT_STEP);
    end else begin
      if (do_push) begin
        mem[wptr] <= din_i;
        wptr      <= (wptr == LAST) ? '0 : wptr + 1'b1;
      end
      if (do_pop)
        rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      if (do_push && !do_pop)
        count <= count + 1'b1;
      else if (do_pop && !do_push)
        count <= count - 1'b1;
    end
  end

  // R3 / R6: a push into a full queue leaves the write side untouched
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wptr)));

  // R2 / R5: a pop of an empty queue leaves the read side untouched
  a_r2_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rptr)));
endmodule

// File: rtl/qpmu_status.sv
module qpmu_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] lvl_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_o   <= '0;
    end else begin
      sticky_q <= (sticky_q & ~clr_i) | set_i;
      if (mask_wr_i)
        mask_o <= mask_wdata_i;
    end
  end

  assign status_o = sticky_q | lvl_i;
  assign irq_o    = |(status_o & ~mask_o);

  // R9: a write-one-clear with no new set empties those bits
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_i & ~set_i) & sticky_q) == '0));

  // R10: a fully masked register never raises its interrupt
  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == {N{1'b1}}) |-> !irq_o);
endmodule

// File: rtl/qpmu_top.sv
module qpmu_top
  import qpmu_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 16,
  parameter int SLOT_BASE = 32'h0000_1000,
  parameter int SLOT_STEP = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              host_irq,
  output logic              lreq_valid,
  input  logic              lreq_ready,
  output logic [31:0]       lreq_data,
  output logic              lreq_host,
  output logic [31:0]       lreq_addr,
  input  logic              lcpl_valid,
  output logic              lcpl_ready,
  input  logic [31:0]       lcpl_data,
  output logic [31:0]       loc_imsg0,
  output logic [31:0]       loc_imsg1,
  input  logic              loc_omsg_wr,
  input  logic              loc_omsg_sel,
  input  logic [31:0]       loc_omsg_data,
  output logic [31:0]       loc_doorbell,
  input  logic [31:0]       loc_db_clr,
  output logic              local_irq
);
  localparam int SHIFT = 5;
  localparam int PAD_W = DATA_W - STS_W;

  // address decode
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic wr_imsg0, wr_imsg1, wr_db, wr_ists, wr_imask, wr_osts, wr_omask, wr_iqp, wr_oqp;
  logic rd_iqp, rd_oqp;

  assign wr_imsg0 = host_wr && hit(host_addr, OFF_IMSG0);
  assign wr_imsg1 = host_wr && hit(host_addr, OFF_IMSG1);
  assign wr_db    = host_wr && hit(host_addr, OFF_DBELL);
  assign wr_ists  = host_wr && hit(host_addr, OFF_ISTS);
  assign wr_imask = host_wr && hit(host_addr, OFF_IMASK);
  assign wr_osts  = host_wr && hit(host_addr, OFF_OSTS);
  assign wr_omask = host_wr && hit(host_addr, OFF_OMASK);
  assign wr_iqp   = host_wr && hit(host_addr, OFF_IQP);
  assign wr_oqp   = host_wr && hit(host_addr, OFF_OQP);
  assign rd_iqp   = host_rd && hit(host_addr, OFF_IQP);
  assign rd_oqp   = host_rd && hit(host_addr, OFF_OQP);

  // free pool: preloaded with slot offsets
  logic [31:0] fp_dout;
  logic        fp_full, fp_empty;

  qpmu_fifo #(.W(DATA_W), .DEPTH(DEPTH), .INIT_FULL(1'b1),
              .INIT_BASE(SLOT_BASE), .INIT_STEP(SLOT_STEP)) u_free_pool (
    .clk, .rst_n,
    .push_i (wr_oqp), .din_i (host_wdata),
    .pop_i  (rd_iqp), .dout_o(fp_dout),
    .full_o (fp_full), .empty_o(fp_empty)
  );

  // posted requests toward the core
  logic iq_full, iq_empty, iq_pop;

  assign iq_pop = lreq_valid && lreq_ready;

  qpmu_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_req_q (
    .clk, .rst_n,
    .push_i (wr_iqp), .din_i (host_wdata),
    .pop_i  (iq_pop), .dout_o(lreq_data),
    .full_o (iq_full), .empty_o(iq_empty)
  );

  assign lreq_valid = !iq_empty;
  assign lreq_host  = lreq_data[31];
  assign lreq_addr  = lreq_host ? {lreq_data[DATA_W-SHIFT-1:0], {SHIFT{1'b0}}} : lreq_data;

  // completions toward the host
  logic [31:0] oq_dout;
  logic        oq_full, oq_empty;

  assign lcpl_ready = !oq_full;

  qpmu_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_cpl_q (
    .clk, .rst_n,
    .push_i (lcpl_valid && lcpl_ready), .din_i(lcpl_data),
    .pop_i  (rd_oqp), .dout_o(oq_dout),
    .full_o (oq_full), .empty_o(oq_empty)
  );

  // messages and doorbell
  logic [31:0] omsg0_q, omsg1_q;
  logic        lw_omsg0, lw_omsg1;

  assign lw_omsg0 = loc_omsg_wr && !loc_omsg_sel;
  assign lw_omsg1 = loc_omsg_wr &&  loc_omsg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_imsg0    <= '0;
      loc_imsg1    <= '0;
      omsg0_q      <= '0;
      omsg1_q      <= '0;
      loc_doorbell <= '0;
    end else begin
      if (wr_imsg0) loc_imsg0 <= host_wdata;
      if (wr_imsg1) loc_imsg1 <= host_wdata;
      if (lw_omsg0) omsg0_q   <= loc_omsg_data;
      if (lw_omsg1) omsg1_q   <= loc_omsg_data;
      loc_doorbell <= (loc_doorbell | (wr_db ? host_wdata : '0)) & ~loc_db_clr;
    end
  end

  // status / mask pairs
  logic [STS_W-1:0] ib_set, ob_set, ob_lvl;
  logic [STS_W-1:0] ib_sts, ib_mask, ob_sts, ob_mask;

  always_comb begin
    ib_set          = '0;
    ib_set[IB_MSG0] = wr_imsg0;
    ib_set[IB_MSG1] = wr_imsg1;
    ib_set[IB_DB]   = wr_db && (host_wdata != '0);
    ib_set[IB_OVF]  = wr_iqp && iq_full;
    ob_set          = '0;
    ob_set[OB_MSG0] = lw_omsg0;
    ob_set[OB_MSG1] = lw_omsg1;
    ob_set[OB_OVF]  = wr_oqp && fp_full;
    ob_lvl          = '0;
    ob_lvl[OB_PEND] = !oq_empty;
  end

  qpmu_status #(.N(STS_W)) u_ib_status (
    .clk, .rst_n,
    .set_i (ib_set), .clr_i(wr_ists ? host_wdata[STS_W-1:0] : '0), .lvl_i('0),
    .mask_wr_i(wr_imask), .mask_wdata_i(host_wdata[STS_W-1:0]),
    .status_o(ib_sts), .mask_o(ib_mask), .irq_o(local_irq)
  );

  qpmu_status #(.N(STS_W)) u_ob_status (
    .clk, .rst_n,
    .set_i (ob_set), .clr_i(wr_osts ? host_wdata[STS_W-1:0] : '0), .lvl_i(ob_lvl),
    .mask_wr_i(wr_omask), .mask_wdata_i(host_wdata[STS_W-1:0]),
    .status_o(ob_sts), .mask_o(ob_mask), .irq_o(host_irq)
  );

  // read path, one register stage
  logic [31:0] rd_word;

  always_comb begin
    rd_word = '0;
    if      (hit(host_addr, OFF_IMSG0)) rd_word = loc_imsg0;
    else if (hit(host_addr, OFF_IMSG1)) rd_word = loc_imsg1;
    else if (hit(host_addr, OFF_OMSG0)) rd_word = omsg0_q;
    else if (hit(host_addr, OFF_OMSG1)) rd_word = omsg1_q;
    else if (hit(host_addr, OFF_DBELL)) rd_word = loc_doorbell;
    else if (hit(host_addr, OFF_ISTS))  rd_word = {{PAD_W{1'b0}}, ib_sts};
    else if (hit(host_addr, OFF_IMASK)) rd_word = {{PAD_W{1'b0}}, ib_mask};
    else if (hit(host_addr, OFF_OSTS))  rd_word = {{PAD_W{1'b0}}, ob_sts};
    else if (hit(host_addr, OFF_OMASK)) rd_word = {{PAD_W{1'b0}}, ob_mask};
    else if (hit(host_addr, OFF_IQP))   rd_word = fp_empty ? EMPTY_WORD : fp_dout;
    else if (hit(host_addr, OFF_OQP))   rd_word = oq_empty ? EMPTY_WORD : oq_dout;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd)
        host_rdata <= rd_word;
    end
  end

  // R2: an empty free pool answers with the all-ones word
  a_r2_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iqp && fp_empty) |=> (host_rvalid && host_rdata == EMPTY_WORD));

  // R11: the request head holds while the core stalls
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && !lreq_ready) |=> (lreq_valid && $stable(lreq_data)));

  // R5: no completion is offered as accepted while the queue is full
  a_r5_cpl_full: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_full && !rd_oqp) |=> !lcpl_ready);
endmodule

// File: tb/test_qpmu_top.sv
`timescale 1ns/1ps
module test_qpmu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        host_rvalid, host_irq;
  logic        lreq_valid, lreq_ready, lreq_host;
  logic [31:0] lreq_data, lreq_addr;
  logic        lcpl_valid, lcpl_ready;
  logic [31:0] lcpl_data;
  logic [31:0] loc_imsg0, loc_imsg1, loc_doorbell, loc_db_clr;
  logic        loc_omsg_wr, loc_omsg_sel;
  logic [31:0] loc_omsg_data;
  logic        local_irq;

  always #2.5 clk = ~clk;

  qpmu_top i_qpmu_top (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
    if (host_rvalid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R2: host_rvalid actual %b expected 1", host_rvalid);
    end
  endtask

  task automatic cpl_push(input logic [31:0] d);
    @(negedge clk);
    lcpl_valid = 1'b1; lcpl_data = d;
    @(negedge clk);
    lcpl_valid = 1'b0;
  endtask

  // op: 0 write, 1 read and compare
  typedef struct packed {
    logic        op;
    logic [7:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h44, 32'hFFFF_FFFF},  // R5 empty completion read
    '{1'b1, 8'h24, 32'h0},          // R1 inbound status
    '{1'b1, 8'h30, 32'h0},          // R1 outbound status
    '{1'b1, 8'h40, 32'h0000_1000},  // R2 first slot
    '{1'b1, 8'h40, 32'h0000_1100},  // R2 second slot
    '{1'b0, 8'h44, 32'h0000_1000},  // R6 return slot
    '{1'b0, 8'h10, 32'hA5A5_0001},  // R7 inbound msg 0
    '{1'b1, 8'h10, 32'hA5A5_0001},  // R7 readback
    '{1'b1, 8'h24, 32'h1},          // R7 status bit 0
    '{1'b0, 8'h24, 32'h1},          // R9 clear
    '{1'b1, 8'h24, 32'h0},          // R9
    '{1'b0, 8'h20, 32'h3},          // R8 doorbell
    '{1'b0, 8'h20, 32'h4},          // R8 doorbell OR
    '{1'b1, 8'h20, 32'h7},          // R8
    '{1'b1, 8'h24, 32'h4},          // R8 status bit 2
    '{1'b0, 8'h18, 32'h1234},       // R7 host write ignored
    '{1'b1, 8'h18, 32'h0},          // R7
    '{1'b0, 8'h28, 32'hF},          // R10 mask
    '{1'b1, 8'h28, 32'hF},          // R10
    '{1'b0, 8'h28, 32'h0},          // R10
    '{1'b0, 8'h24, 32'hF},          // R9
    '{1'b1, 8'h24, 32'h0}           // R9
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    lreq_ready = 0; lcpl_valid = 0; lcpl_data = 0;
    loc_omsg_wr = 0; loc_omsg_sel = 0; loc_omsg_data = 0; loc_db_clr = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset levels
    check("R1 host_irq", {31'b0, host_irq}, 32'h0);
    check("R1 local_irq", {31'b0, local_irq}, 32'h0);
    check("R1 lreq_valid", {31'b0, lreq_valid}, 32'h0);
    check("R1 lcpl_ready", {31'b0, lcpl_ready}, 32'h1);

    foreach (VEC[i]) begin
      if (VEC[i].op) begin
        hread(VEC[i].addr, rd);
        check($sformatf("vector %0d addr 0x%02h", i, VEC[i].addr), rd, VEC[i].data);
      end else begin
        hwrite(VEC[i].addr, VEC[i].data);
      end
    end

    // R7 / R10 inbound message 1 and local interrupt
    hwrite(8'h14, 32'h0BAD_F00D);
    check("R7 loc_imsg1", loc_imsg1, 32'h0BAD_F00D);
    check("R7 loc_imsg0", loc_imsg0, 32'hA5A5_0001);
    check("R10 local_irq set", {31'b0, local_irq}, 32'h1);
    hwrite(8'h28, 32'h2);
    check("R10 local_irq masked", {31'b0, local_irq}, 32'h0);
    hwrite(8'h28, 32'h0);
    hwrite(8'h24, 32'h2);
    check("R10 local_irq cleared", {31'b0, local_irq}, 32'h0);

    // R8 local clear of doorbell bit 0
    @(negedge clk); loc_db_clr = 32'h1;
    @(negedge clk); loc_db_clr = 32'h0;
    check("R8 doorbell clear", loc_doorbell, 32'h6);

    // R2 drain the pool in order
    for (int i = 0; i < 14; i++) begin
      hread(8'h40, rd);
      check("R2 pool order", rd, 32'h1200 + i * 32'h100);
    end
    hread(8'h40, rd);
    check("R6 returned slot order", rd, 32'h1000);
    hread(8'h40, rd);
    check("R2 empty pool", rd, 32'hFFFF_FFFF);
    hread(8'h40, rd);
    check("R2 empty pool unchanged", rd, 32'hFFFF_FFFF);

    // R6 refill and overflow
    for (int i = 0; i < 16; i++) hwrite(8'h44, 32'h2000 + i * 32'h20);
    check("R6 irq before overflow", {31'b0, host_irq}, 32'h0);
    hwrite(8'h44, 32'hDEAD_0000);
    hread(8'h30, rd);
    check("R6 return overflow bit", rd, 32'h8);
    check("R10 host_irq on overflow", {31'b0, host_irq}, 32'h1);
    hread(8'h40, rd);
    check("R6 refill order", rd, 32'h2000);
    hwrite(8'h30, 32'h8);
    check("R9 host_irq after clear", {31'b0, host_irq}, 32'h0);

    // R3 / R4 / R11 posted requests
    hwrite(8'h40, 32'h8000_0010);
    check("R3 lreq_valid", {31'b0, lreq_valid}, 32'h1);
    check("R4 host flag", {31'b0, lreq_host}, 32'h1);
    check("R4 host address", lreq_addr, 32'h0000_0200);
    repeat (3) @(negedge clk);
    check("R11 head stable", lreq_data, 32'h8000_0010);
    for (int i = 0; i < 15; i++) hwrite(8'h40, 32'h3000 + i);
    check("R3 no overflow yet", {28'b0, i_qpmu_top.ib_sts} & 32'h0, 32'h0);
    hwrite(8'h40, 32'h7777_7777);
    hread(8'h24, rd);
    check("R3 post overflow bit", rd, 32'h8);
    check("R10 local_irq on overflow", {31'b0, local_irq}, 32'h1);
    @(negedge clk); lreq_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i == 0) check("R3 order head", lreq_data, 32'h8000_0010);
      else begin
        check("R3 order", lreq_data, 32'h3000 + i - 1);
        check("R4 offset form", lreq_addr, 32'h3000 + i - 1);
        check("R4 offset flag", {31'b0, lreq_host}, 32'h0);
      end
      @(negedge clk);
    end
    lreq_ready = 1'b0;
    check("R3 overflow value dropped", {31'b0, lreq_valid}, 32'h0);
    hwrite(8'h24, 32'h8);

    // R7 outbound message from the core
    @(negedge clk); loc_omsg_wr = 1; loc_omsg_sel = 0; loc_omsg_data = 32'hA5A5_0001;
    @(negedge clk); loc_omsg_sel = 1; loc_omsg_data = 32'h5A5A_0002;
    @(negedge clk); loc_omsg_wr = 0;
    hread(8'h18, rd);
    check("R7 outbound msg 0", rd, 32'hA5A5_0001);
    hread(8'h1C, rd);
    check("R7 outbound msg 1", rd, 32'h5A5A_0002);
    hread(8'h30, rd);
    check("R7 outbound status", rd, 32'h6);
    hwrite(8'h30, 32'h6);

    // R5 / R9 / R10 completions
    cpl_push(32'h8000_0010);
    cpl_push(32'h3000);
    cpl_push(32'hC0DE_0001);
    check("R10 host_irq pending", {31'b0, host_irq}, 32'h1);
    hwrite(8'h34, 32'h1);
    check("R10 host_irq masked", {31'b0, host_irq}, 32'h0);
    hwrite(8'h34, 32'h0);
    hwrite(8'h30, 32'h1);
    hread(8'h30, rd);
    check("R9 pending bit not clearable", rd, 32'h1);
    hread(8'h44, rd); check("R5 completion 0", rd, 32'h8000_0010);
    hread(8'h44, rd); check("R5 completion 1", rd, 32'h3000);
    hread(8'h44, rd); check("R5 completion 2", rd, 32'hC0DE_0001);
    hread(8'h44, rd); check("R5 drained", rd, 32'hFFFF_FFFF);
    check("R10 host_irq drained", {31'b0, host_irq}, 32'h0);
    for (int i = 0; i < 16; i++) cpl_push(32'h100 + i);
    check("R5 lcpl_ready full", {31'b0, lcpl_ready}, 32'h0);
    hread(8'h44, rd);
    check("R5 full head", rd, 32'h100);
    check("R5 lcpl_ready after pop", {31'b0, lcpl_ready}, 32'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule